// File: doc/BRIEF.md
# CAN Controller Low-Power Mode Sequencer

This block sits beside a CAN protocol engine and controls its sleep, wake-up and power-down behaviour. Software asks for sleep by writing a request bit. The block grants it with an acknowledge only once the bus is idle. While asleep, the block either masks the receive line or watches it for a wake-up, depending on the wake-up-enable bit that was latched when sleep began. After any wake-up, the engine is held off the bus until the bus has been seen recessive for 11 bit times in a row.

The block also forces the controller into power-down when the CPU stops, or when the CPU waits while the clock-stop-in-wait bit is set. In power-down the transmit pin is forced recessive. If the controller was not asleep when power-down began, a recovery delay of fixed length is inserted on power-up before the resynchronisation. Work that was pending before sleep is released with a one-cycle pulse on wake-up. The bus-off recovery count of 11-bit recessive runs is frozen across sleep and is not restarted.

Top module: `canlp_seq`

## Requirements
- R1: After synchronous reset, req_o=0, sleep_ack_o=0, wake_irq_o=0, rx_int_o=1, tx_rec_o=0, ready_o=1, pend_rel_o=0 and boff_done_o=0.
- R2: A register write (req_wr_i=1) with req_wdata_i=1 sets req_o at that clock edge. sleep_ack_o rises at the first edge at which req_o=1 and bus_idle_i=1, and stays 0 while bus_idle_i=0.
- R3: A write with req_wdata_i=0 while sleep_ack_o=0 leaves req_o at 1.
- R4: wake_en_i is sampled only at sleep entry, and later changes to it have no effect. If the sampled value was 0, no level or duration of dominant rx_i ends sleep, and rx_int_o stays 1. Outside sleep and power-down, rx_int_o equals rx_i as sampled at the previous edge.
- R5: If the sampled wake-up enable was 1, a run of FILT_CYC consecutive clocks with rx_i=0 during sleep ends it at the last of those edges: sleep_ack_o and req_o go to 0 and wake_irq_o goes to 1. Shorter dominant pulses are ignored. wake_irq_o stays 1 until an edge with irq_clr_i=1.
- R6: A write with req_wdata_i=0 while sleep_ack_o=1 ends sleep at that edge. sleep_ack_o and req_o go to 0, and wake_irq_o is not set.
- R7: After a wake-up, ready_o stays 0 until 11 consecutive bit_tick_i cycles with rx_i=1 have been seen. A tick with rx_i=0 restarts the count. ready_o becomes 1 at the edge of the 11th tick.
- R8: pend_rel_o pulses for exactly one cycle at the edge where sleep ends if pend_i=1 at that edge, and otherwise stays 0.
- R9: While bus_off_i=1, each run of 11 consecutive recessive ticks counts once, and boff_done_o becomes 1 at the end of the 128th run. Counting is frozen, not reset, during sleep and power-down. An edge with bus_off_i=0 clears the count and boff_done_o.
- R10: Power-down is entered when cpu_stop_i=1, or when cpu_wait_i=1 together with clk_stop_wait_i=1. cpu_wait_i alone does not enter it. At the entry edge, tx_rec_o goes to 1, ready_o goes to 0 and rx_int_o goes to 1.
- R11: Power-down entered from sleep returns to sleep on exit, with sleep_ack_o held at 1 throughout and no recovery delay.
- R12: Power-down entered from any state other than sleep is followed on exit by REC_BITS bit ticks of recovery and then the 11-tick resynchronisation before ready_o returns to 1.
- R13: Register writes made while in power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr_i | input | 1 | Write strobe for the sleep-request bit |
| req_wdata_i | input | 1 | Value written to the sleep-request bit |
| wake_en_i | input | 1 | Wake-up on bus activity enable |
| clk_stop_wait_i | input | 1 | Stop clocks when the CPU waits |
| cpu_stop_i | input | 1 | CPU is in stop mode |
| cpu_wait_i | input | 1 | CPU is in wait mode |
| rx_i | input | 1 | Receive pin, 0 is dominant |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| bus_idle_i | input | 1 | Protocol engine sees the bus idle |
| bus_off_i | input | 1 | Protocol engine is bus-off |
| pend_i | input | 1 | Actions held pending for wake-up |
| irq_clr_i | input | 1 | Clears the wake-up interrupt |
| req_o | output | 1 | Current sleep-request bit |
| sleep_ack_o | output | 1 | Sleep is active |
| wake_irq_o | output | 1 | Wake-up by bus activity occurred |
| rx_int_o | output | 1 | Masked receive line to the engine |
| tx_rec_o | output | 1 | Force transmit pin recessive |
| ready_o | output | 1 | Engine may run normally |
| pend_rel_o | output | 1 | Pulse releasing pending actions |
| boff_done_o | output | 1 | 128 recessive runs seen while bus-off |

## Verification
The hardest situation to reach is a bus-off recovery count that is partly done, then frozen through a whole sleep period with recessive ticks still arriving, then resumed so that it finishes at exactly the 128th run. The stimulus delivers exactly 100 runs, enters sleep and feeds 600 further ticks that must not count. It then wakes by software and counts the resynchronisation run as the 101st. Finally it checks boff_done_o one tick before and at the final tick. Noise just shorter than the filter time is produced with random pulse lengths from a fixed seed, to show that such noise never wakes the block.

// File: rtl/canlp_pkg.sv
package canlp_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_SYNC,
    ST_PDOWN,
    ST_RECOV
  } mode_t;
endpackage

// File: rtl/canlp_wake_filt.sv
module canlp_wake_filt #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic rx_i,
  output logic hit_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm_i || rx_i) cnt <= '0;
    else if (cnt != LAST)      cnt <= cnt + 1'b1;
  end

  assign hit_o = arm_i && !rx_i && (cnt == LAST);

  generate
    if (FILT_CYC > 1) begin : g_chk
      // R5
      filt_len_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ($past(!rx_i) && $past(arm_i)));
    end
  endgenerate
endmodule

// File: rtl/canlp_run_cnt.sv
module canlp_run_cnt #(
  parameter int RUN_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic clr_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic run_o
);
  localparam int CW = $clog2(RUN_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_BITS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i)          cnt <= '0;
    else if (en_i && tick_i) begin
      if (!rx_i || cnt == LAST) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
    end
  end

  assign run_o = en_i && tick_i && rx_i && (cnt == LAST);
endmodule

// File: rtl/canlp_boff_cnt.sv
module canlp_boff_cnt #(
  parameter int BO_RUNS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_off_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(BO_RUNS + 1);
  localparam logic [CW-1:0] LAST = CW'(BO_RUNS - 1);
  localparam logic [CW-1:0] FULL = CW'(BO_RUNS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !bus_off_i) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (run_i && cnt != FULL) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done_o <= 1'b1;
    end
  end

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && bus_off_i) |=> done_o);
endmodule

// File: rtl/canlp_mode_fsm.sv
module canlp_mode_fsm
  import canlp_pkg::*;
#(
  parameter int REC_BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic wake_en_i,
  input  logic csw_i,
  input  logic cpu_stop_i,
  input  logic cpu_wait_i,
  input  logic rx_i,
  input  logic tick_i,
  input  logic bus_idle_i,
  input  logic pend_i,
  input  logic irq_clr_i,
  input  logic hit_i,
  input  logic run_i,
  output logic req_o,
  output logic ack_o,
  output logic irq_o,
  output logic rx_int_o,
  output logic tx_rec_o,
  output logic ready_o,
  output logic pend_rel_o,
  output logic arm_o,
  output logic run_en_o,
  output logic run_clr_o
);
  localparam int RW = $clog2(REC_BITS + 1);
  localparam logic [RW-1:0] RLAST = RW'(REC_BITS - 1);

  mode_t         state, nxt;
  logic          wen_q, fs_q, wen_nxt, fs_nxt;
  logic [RW-1:0] rcnt;
  logic          pd, acc, sw_clr, bus_wake;

  assign pd       = cpu_stop_i || (cpu_wait_i && csw_i);
  assign acc      = !pd && (state != ST_PDOWN);
  assign sw_clr   = acc && wr_i && !wdata_i && req_o && ack_o;
  assign bus_wake = (state == ST_SLEEP) && hit_i && !pd;

  always_comb begin
    nxt = state;
    if (pd) nxt = ST_PDOWN;
    else begin
      case (state)
        ST_RUN:   if (req_o && bus_idle_i) nxt = ST_SLEEP;
        ST_SLEEP: if (sw_clr || hit_i) nxt = ST_SYNC;
        ST_SYNC:  if (run_i) nxt = ST_RUN;
        ST_PDOWN: nxt = fs_q ? ST_SLEEP : ST_RECOV;
        ST_RECOV: if (tick_i && rcnt == RLAST) nxt = ST_SYNC;
        default:  nxt = ST_RUN;
      endcase
    end
  end

  assign wen_nxt = (nxt == ST_SLEEP && state != ST_SLEEP && state != ST_PDOWN)
                   ? wake_en_i : wen_q;
  assign fs_nxt  = (state == ST_PDOWN) ? fs_q : (state == ST_SLEEP);

  assign arm_o     = (state == ST_SLEEP) && wen_q;
  assign run_en_o  = (state == ST_RUN) || (state == ST_SYNC) || (state == ST_RECOV);
  assign run_clr_o = (nxt == ST_SYNC) && (state != ST_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      req_o      <= 1'b0;
      ack_o      <= 1'b0;
      irq_o      <= 1'b0;
      rx_int_o   <= 1'b1;
      tx_rec_o   <= 1'b0;
      ready_o    <= 1'b1;
      pend_rel_o <= 1'b0;
      wen_q      <= 1'b0;
      fs_q       <= 1'b0;
      rcnt       <= '0;
    end else begin
      state <= nxt;
      wen_q <= wen_nxt;
      if (nxt == ST_PDOWN) fs_q <= fs_nxt;
      if (acc && wr_i && wdata_i)  req_o <= 1'b1;
      else if (sw_clr || bus_wake) req_o <= 1'b0;
      if (bus_wake)       irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
      if (state != ST_RECOV) rcnt <= '0;
      else if (tick_i)       rcnt <= rcnt + 1'b1;
      ack_o      <= (nxt == ST_SLEEP) || (nxt == ST_PDOWN && fs_nxt);
      tx_rec_o   <= (nxt == ST_SLEEP) || (nxt == ST_PDOWN);
      ready_o    <= (nxt == ST_RUN);
      pend_rel_o <= (state == ST_SLEEP) && (nxt == ST_SYNC) && pend_i;
      rx_int_o   <= ((nxt == ST_PDOWN) || (nxt == ST_SLEEP && !wen_nxt)) ? 1'b1 : rx_i;
    end
  end

  // R2
  ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> req_o);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_o) |=> req_o);
  // R4
  rx_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !wen_q) |-> rx_int_o);
  // R4
  no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && !wen_q && !pd && !(wr_i && !wdata_i)) |=> ack_o);
  // R10
  pd_tx_chk: assert property (@(posedge clk) disable iff (rst)
    pd |=> (tx_rec_o && !ready_o));
  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(state == ST_SYNC));
endmodule

// File: rtl/canlp_seq.sv
module canlp_seq #(
  parameter int FILT_CYC = 4,
  parameter int RUN_BITS = 11,
  parameter int REC_BITS = 16,
  parameter int BO_RUNS  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic req_wr_i,
  input  logic req_wdata_i,
  input  logic wake_en_i,
  input  logic clk_stop_wait_i,
  input  logic cpu_stop_i,
  input  logic cpu_wait_i,
  input  logic rx_i,
  input  logic bit_tick_i,
  input  logic bus_idle_i,
  input  logic bus_off_i,
  input  logic pend_i,
  input  logic irq_clr_i,
  output logic req_o,
  output logic sleep_ack_o,
  output logic wake_irq_o,
  output logic rx_int_o,
  output logic tx_rec_o,
  output logic ready_o,
  output logic pend_rel_o,
  output logic boff_done_o
);
  logic arm, hit, run, run_en, run_clr;

  canlp_wake_filt #(.FILT_CYC(FILT_CYC)) i_filt (
    .clk(clk), .rst(rst), .arm_i(arm), .rx_i(rx_i), .hit_o(hit)
  );

  canlp_run_cnt #(.RUN_BITS(RUN_BITS)) i_run (
    .clk(clk), .rst(rst), .en_i(run_en), .clr_i(run_clr),
    .tick_i(bit_tick_i), .rx_i(rx_i), .run_o(run)
  );

  canlp_boff_cnt #(.BO_RUNS(BO_RUNS)) i_boff (
    .clk(clk), .rst(rst), .bus_off_i(bus_off_i), .run_i(run), .done_o(boff_done_o)
  );

  canlp_mode_fsm #(.REC_BITS(REC_BITS)) i_fsm (
    .clk(clk), .rst(rst), .wr_i(req_wr_i), .wdata_i(req_wdata_i),
    .wake_en_i(wake_en_i), .csw_i(clk_stop_wait_i), .cpu_stop_i(cpu_stop_i),
    .cpu_wait_i(cpu_wait_i), .rx_i(rx_i), .tick_i(bit_tick_i),
    .bus_idle_i(bus_idle_i), .pend_i(pend_i), .irq_clr_i(irq_clr_i),
    .hit_i(hit), .run_i(run), .req_o(req_o), .ack_o(sleep_ack_o),
    .irq_o(wake_irq_o), .rx_int_o(rx_int_o), .tx_rec_o(tx_rec_o),
    .ready_o(ready_o), .pend_rel_o(pend_rel_o), .arm_o(arm),
    .run_en_o(run_en), .run_clr_o(run_clr)
  );
endmodule

// File: tb/test_canlp_seq.sv
`timescale 1ns/1ps
module test_canlp_seq;
  localparam int FILT = 4;
  localparam int RUNB = 11;
  localparam int RECB = 16;
  localparam int BOR  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 0, wd = 0, wen = 0, csw = 0, cstop = 0, cwait = 0;
  logic rx = 1, tick = 0, idle = 0, boff = 0, pend = 0, iclr = 0;
  logic req, ack, irq, rxi, txr, rdy, prel, bdone;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  canlp_seq #(.FILT_CYC(FILT), .RUN_BITS(RUNB), .REC_BITS(RECB), .BO_RUNS(BOR)) i_canlp_seq (
    .clk(clk), .rst(rst), .req_wr_i(wr), .req_wdata_i(wd), .wake_en_i(wen),
    .clk_stop_wait_i(csw), .cpu_stop_i(cstop), .cpu_wait_i(cwait), .rx_i(rx),
    .bit_tick_i(tick), .bus_idle_i(idle), .bus_off_i(boff), .pend_i(pend),
    .irq_clr_i(iclr), .req_o(req), .sleep_ack_o(ack), .wake_irq_o(irq),
    .rx_int_o(rxi), .tx_rec_o(txr), .ready_o(rdy), .pend_rel_o(prel),
    .boff_done_o(bdone)
  );

  function automatic int pulse_len(int lim);
    return 1 + int'($urandom % lim);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ticks(int n, logic v);
    tick = 1'b1;
    rx   = v;
    step(n);
    tick = 1'b0;
  endtask

  task automatic wr_req(logic v);
    wr = 1'b1;
    wd = v;
    step();
    wr = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    step(2);
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 req", req, 0);  chk("R1 ack", ack, 0);  chk("R1 irq", irq, 0);
    chk("R1 rx_int", rxi, 1); chk("R1 tx", txr, 0); chk("R1 ready", rdy, 1);
    chk("R1 pend", prel, 0); chk("R1 boff", bdone, 0);

    // R4 pass-through outside sleep
    rx = 0; step(); chk("R4 rx follows", rxi, 0);
    rx = 1; step(); chk("R4 rx follows", rxi, 1);

    // R2 request while bus busy
    idle = 0; wr_req(1);
    chk("R2 req set", req, 1); chk("R2 no ack busy", ack, 0);
    step(3); chk("R2 no ack busy", ack, 0);
    // R3 early clear ignored
    wr_req(0); chk("R3 clear ignored", req, 1);
    wen = 0; idle = 1; step();
    chk("R2 ack", ack, 1); chk("R2 tx rec", txr, 1); chk("R2 ready low", rdy, 0);

    // R4 enable changed after entry, dominant bus
    wen = 1; rx = 0; step(20);
    chk("R4 no wake", ack, 1); chk("R4 masked", rxi, 1); chk("R4 no irq", irq, 0);
    rx = 1; step();

    // R6 software wake with pending work, R8
    pend = 1; wr_req(0);
    chk("R6 ack drop", ack, 0); chk("R6 req drop", req, 0); chk("R6 no irq", irq, 0);
    chk("R8 pulse", prel, 1);
    pend = 0; step(); chk("R8 one cycle", prel, 0);

    // R7 resync with restart
    ticks(5, 1); ticks(1, 0); ticks(10, 1);
    chk("R7 not ready", rdy, 0);
    ticks(1, 1); chk("R7 ready", rdy, 1);

    // R5 bus wake with noise
    wen = 1; wr_req(1); step();
    chk("R5 asleep", ack, 1);
    wen = 0;
    rx = 0; step(); chk("R5 rx visible", rxi, 0);
    rx = 1; step();
    for (int i = 0; i < 30; i++) begin
      rx = 0; step(pulse_len(FILT - 1));
      rx = 1; step(pulse_len(3));
      chk("R5 noise ignored", ack, 1);
    end
    rx = 0; step(FILT - 1); chk("R5 short", ack, 1);
    step(); chk("R5 woke", ack, 0); chk("R5 irq", irq, 1); chk("R5 req", req, 0);
    chk("R8 no pend", prel, 0);
    rx = 1; step(3); chk("R5 irq held", irq, 1);
    iclr = 1; step(); iclr = 0; chk("R5 irq clr", irq, 0);
    ticks(RUNB, 1); chk("R7 ready after bus wake", rdy, 1);

    // R10 power-down conditions
    cwait = 1; csw = 0; step(3);
    chk("R10 wait alone", rdy, 1); chk("R10 wait alone tx", txr, 0);
    csw = 1; rx = 0; step();
    chk("R10 tx", txr, 1); chk("R10 ready", rdy, 0); chk("R10 rx_int", rxi, 1);
    // R13 writes ignored
    wr_req(1); chk("R13 ignored", req, 0);
    rx = 1; cwait = 0; csw = 0; step();
    chk("R12 tx off", txr, 0); chk("R12 ready low", rdy, 0); chk("R12 no ack", ack, 0);
    ticks(RECB - 1, 1); chk("R12 recov", rdy, 0);
    ticks(1, 1); ticks(RUNB - 1, 1); chk("R12 sync", rdy, 0);
    ticks(1, 1); chk("R12 ready", rdy, 1);

    // R11 power-down from sleep
    wen = 0; wr_req(1); step(); chk("R11 asleep", ack, 1);
    cstop = 1; step(); chk("R11 ack in pd", ack, 1); chk("R11 tx", txr, 1);
    cstop = 0; rx = 0; step();
    chk("R11 back asleep", ack, 1); chk("R11 ready", rdy, 0); chk("R11 masked", rxi, 1);
    rx = 1; step(); wr_req(0); chk("R11 woke", ack, 0);
    ticks(RUNB, 1); chk("R11 ready", rdy, 1);

    // R9 bus-off count frozen across sleep
    boff = 1; ticks(100 * RUNB, 1); chk("R9 partial", bdone, 0);
    wr_req(1); step(); chk("R9 asleep", ack, 1);
    ticks(600, 1); chk("R9 frozen", bdone, 0);
    wr_req(0); ticks(RUNB, 1); chk("R9 sync", rdy, 1);
    ticks(26 * RUNB + RUNB - 1, 1); chk("R9 before last", bdone, 0);
    ticks(1, 1); chk("R9 done", bdone, 1);
    boff = 0; step(); chk("R9 clear", bdone, 0);

    summary();
  end
endmodule